// File: doc/BRIEF.md
# Voltage Set-Point Write Sequencer

This block takes one voltage set-point request at a time from a request arbiter and drives it to a target regulator over an embedded I2C controller. The block reaches that controller, and an optional shared mutex, through a byte-wide single-access bus master port. The I2C bit layer is not part of the block: the controller is seen only as a small set of byte registers for command, status, transmit data and receive data.

For each request the sequencer does several things in a fixed order. It claims the mutex, then polls the controller until the external bus is idle, and only then releases the target's write-protect. It sends the 13-bit set point to the addressed target register. If arbitration is lost during that write, it protects the target again, waits for the bus to go idle and sends the whole write again. It then reads the register back. It reports success only when the read-back value equals the value it sent, and on a failure the arbiter keeps the request pending. At the end of every request the sequencer restores write-protect and frees the mutex. It then waits a fixed number of slow-clock ticks before it accepts the next request.

The request input is a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the result has been reported and the inter-request gap has run out. A source may hold `req_valid` high with stable fields while `req_ready` is low. The result output is a one-cycle pulse with no back-pressure.

Top module: `vidseq_master`

## Requirements
- R1: With no accepted request outstanding, the block starts no bus access (`bm_cyc` stays low). During an access, address, direction and write data stay constant until `bm_ack`.
- R2: When the mutex is enabled, the block writes `{1, OWNER_ID}` to address `ADR_MTX` and then reads that address back. It touches no controller register until the read returns `{1, OWNER_ID}`, and it repeats the write and read while the read returns anything else.
- R3: Before the first START, the block polls the status register (`ADR_SR`) until bit 7 (bus busy) is 0. Only then does it drive `wp_o` low. `wp_o` is low whenever a set-point data byte is sent.
- R4: The write is four byte steps, each a transmit byte written to `ADR_TXDR` followed by a command written to `ADR_CMD`. The bytes are: address with bit 0 = 0 (command 0x90, START|WR), register number (0x10, WR), `data[7:0]` (0x10), and `{3'b000, data[12:8]}` (0x50, WR|STOP). After each command the block polls `ADR_SR` until bit 0 (done), bit 2 (NACK) or bit 3 (arbitration lost) is set.
- R5: If bit 3 is set while polling in the write phase, the block drives `wp_o` high, polls until bus busy is clear, drives `wp_o` low and sends the write again from the address byte.
- R6: The read-back sends the address with bit 0 = 0 (START|WR), then the register number (WR), then the address with bit 0 = 1 (START|WR). It then issues 0x20 (RD) and 0x60 (RD|STOP) and reads `ADR_RXDR` after each. If `{high, low}` equals `{3'b000, data}`, the block reports `res_ok` = 1.
- R7: A read-back that differs from the value sent gives `res_ok` = 0.
- R8: After reset and at the end of every request, whether it passed or failed, `wp_o` is high and the mutex is released by writing `{0, OWNER_ID}` to `ADR_MTX`. This happens before `res_valid`, which is a single-cycle pulse carrying the request's channel.
- R9: A NACK on any byte ends the attempt with `res_ok` = 0. No further byte is sent and `ADR_RXDR` is not read.
- R10: After each `res_valid`, `req_ready` stays low until `WAIT_TICKS` pulses of `slow_tick` have passed. A tick in the cycle the gap starts does not count. After reset, `req_ready` is high.
- R11: `req_ready` is low from the acceptance edge until the gap ends, and each handshake yields exactly one result.
- R12: Targets use 7-bit addressing. The address sent is `{req_slave, direction}`, so a target whose address differs answers with NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle strobe of the slow clock, used to time the gap |
| req_valid | input | 1 | Request available |
| req_ready | output | 1 | Request can be taken |
| req_chan | input | CH_W | Channel tag of the request |
| req_slave | input | 7 | 7-bit I2C address of the target |
| req_reg | input | 8 | Set-point register number in the target |
| req_data | input | 13 | Set-point value |
| res_valid | output | 1 | One-cycle result pulse |
| res_ok | output | 1 | 1 = read-back matched |
| res_chan | output | CH_W | Channel tag of the finished request |
| bm_cyc | output | 1 | Bus cycle active |
| bm_stb | output | 1 | Bus strobe |
| bm_we | output | 1 | 1 = write, 0 = read |
| bm_adr | output | ADR_W | Register address |
| bm_wdat | output | 8 | Write data |
| bm_rdat | input | 8 | Read data |
| bm_ack | input | 1 | Access acknowledge |
| wp_o | output | 1 | Target write-protect, 1 = protected |

## Verification
The bench models the mutex, the I2C controller registers and a target register file, and it checks every bus access and every clock against that model. A plain request checks the byte order and the stored 13-bit value. A mutex held by another owner for two tries separates a correct retry from a skipped ownership check. A bus that stays busy for several polls shows whether START waits for idle. An arbitration loss on the low data byte separates a full retransmission with write-protect raised from a partial one. A corrupted read-back and an absent target address separate the two failure paths: a mismatch after the read-back, and a NACK with no read-back. Extreme data values and the last register pair check the field packing. Requests issued back to back check the gap tick count and the back-pressure.

// File: rtl/vidseq_pkg.sv
package vidseq_pkg;
  // controller command bits
  localparam logic [7:0] CMD_START = 8'h80;
  localparam logic [7:0] CMD_STOP  = 8'h40;
  localparam logic [7:0] CMD_RD    = 8'h20;
  localparam logic [7:0] CMD_WR    = 8'h10;
  // controller status bit positions
  localparam int SR_BUSY = 7;
  localparam int SR_ARBL = 3;
  localparam int SR_NACK = 2;
  localparam int SR_DONE = 0;
  // byte steps per request
  localparam int NUM_STEPS = 9;
  localparam int WR_STEPS  = 4;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam int VAL_W     = 13;

  typedef enum logic [3:0] {
    ST_IDLE, ST_MTX_REQ, ST_MTX_CHK, ST_BUSY, ST_TX, ST_CMD,
    ST_POLL, ST_RX, ST_SETTLE, ST_MTX_FREE, ST_REPORT
  } seq_state_t;
endpackage

// File: rtl/vidseq_busport.sv
module vidseq_busport #(
  parameter int ADR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_we,
  input  logic [ADR_W-1:0] go_adr,
  input  logic [7:0]       go_wdat,
  output logic             done,
  output logic [7:0]       rdat,
  output logic             bm_cyc,
  output logic             bm_stb,
  output logic             bm_we,
  output logic [ADR_W-1:0] bm_adr,
  output logic [7:0]       bm_wdat,
  input  logic [7:0]       bm_rdat,
  input  logic             bm_ack
);
  assign bm_stb = bm_cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bm_cyc  <= 1'b0;
      bm_we   <= 1'b0;
      bm_adr  <= '0;
      bm_wdat <= '0;
      done    <= 1'b0;
      rdat    <= '0;
    end else begin
      done <= 1'b0;
      if (bm_cyc) begin
        if (bm_ack) begin
          bm_cyc <= 1'b0;
          done   <= 1'b1;
          rdat   <= bm_rdat;
        end
      end else if (go) begin
        bm_cyc  <= 1'b1;
        bm_we   <= go_we;
        bm_adr  <= go_adr;
        bm_wdat <= go_wdat;
      end
    end
  end

  // R1: access fields held until acknowledge
  a_r1_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_cyc && !bm_ack) |=> (bm_cyc && $stable(bm_adr) && $stable(bm_we) && $stable(bm_wdat)));
  // R1: a new access is only requested while the port is free
  a_r1_go_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !bm_cyc);
endmodule

// File: rtl/vidseq_step.sv
module vidseq_step
  import vidseq_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  logic [6:0]        slave,
  input  logic [7:0]        regsel,
  input  logic [VAL_W-1:0]  value,
  output logic              has_tx,
  output logic [7:0]        tx_byte,
  output logic [7:0]        cmd,
  output logic              has_rx,
  output logic              wr_phase,
  output logic              last
);
  always_comb begin
    has_tx  = 1'b1;
    has_rx  = 1'b0;
    tx_byte = 8'h00;
    cmd     = CMD_WR;
    unique case (step)
      STEP_W'(0), STEP_W'(4): begin tx_byte = {slave, 1'b0}; cmd = CMD_START | CMD_WR; end
      STEP_W'(1), STEP_W'(5): tx_byte = regsel;
      STEP_W'(2):             tx_byte = value[7:0];
      STEP_W'(3): begin tx_byte = {3'b000, value[12:8]}; cmd = CMD_WR | CMD_STOP; end
      STEP_W'(6): begin tx_byte = {slave, 1'b1}; cmd = CMD_START | CMD_WR; end
      STEP_W'(7): begin has_tx = 1'b0; has_rx = 1'b1; cmd = CMD_RD; end
      default:    begin has_tx = 1'b0; has_rx = 1'b1; cmd = CMD_RD | CMD_STOP; end
    endcase
    wr_phase = (step < STEP_W'(WR_STEPS));
    last     = (step == STEP_W'(NUM_STEPS - 1));
  end
endmodule

// File: rtl/vidseq_gap.sv
module vidseq_gap #(
  parameter int WAIT_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic clear
);
  generate
    if (WAIT_TICKS == 0) begin : g_none
      assign clear = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(WAIT_TICKS + 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= CW'(WAIT_TICKS);
        else if (tick && cnt != '0) cnt <= cnt - 1'b1;
      end
      assign clear = (cnt == '0);

      // R10: the gap counter never exceeds its configured length
      a_r10_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(WAIT_TICKS));
      // R10: loading always starts a non-empty gap
      a_r10_gap_starts: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !clear);
    end
  endgenerate
endmodule

// File: rtl/vidseq_master.sv
module vidseq_master
  import vidseq_pkg::*;
#(
  parameter int             CH_W       = 4,
  parameter int             ADR_W      = 8,
  parameter bit             MUTEX_EN   = 1'b1,
  parameter logic [6:0]     OWNER_ID   = 7'h05,
  parameter int             WAIT_TICKS = 4,
  parameter logic [ADR_W-1:0] ADR_CMD  = ADR_W'(8'h01),
  parameter logic [ADR_W-1:0] ADR_SR   = ADR_W'(8'h02),
  parameter logic [ADR_W-1:0] ADR_TXDR = ADR_W'(8'h03),
  parameter logic [ADR_W-1:0] ADR_RXDR = ADR_W'(8'h04),
  parameter logic [ADR_W-1:0] ADR_MTX  = ADR_W'(8'h10)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CH_W-1:0]  req_chan,
  input  logic [6:0]       req_slave,
  input  logic [7:0]       req_reg,
  input  logic [12:0]      req_data,
  output logic             res_valid,
  output logic             res_ok,
  output logic [CH_W-1:0]  res_chan,
  output logic             bm_cyc,
  output logic             bm_stb,
  output logic             bm_we,
  output logic [ADR_W-1:0] bm_adr,
  output logic [7:0]       bm_wdat,
  input  logic [7:0]       bm_rdat,
  input  logic             bm_ack,
  output logic             wp_o
);
  localparam logic [7:0] MTX_CLAIM = {1'b1, OWNER_ID};
  localparam logic [7:0] MTX_FREE  = {1'b0, OWNER_ID};

  seq_state_t        st;
  logic [STEP_W-1:0] step;
  logic              inflight;
  logic              go, go_we;
  logic [ADR_W-1:0]  go_adr;
  logic [7:0]        go_wdat;
  logic              port_done;
  logic [7:0]        rdat;
  logic              wp_q, mtx_held, ok_q;
  logic [CH_W-1:0]   chan_q;
  logic [6:0]        slave_q;
  logic [7:0]        reg_q;
  logic [VAL_W-1:0]  data_q;
  logic [7:0]        rx_lo;
  logic              gap_clear;
  logic              has_tx, has_rx, wr_phase, last;
  logic [7:0]        tx_byte, cmd;

  vidseq_step u_step (
    .step(step), .slave(slave_q), .regsel(reg_q), .value(data_q),
    .has_tx(has_tx), .tx_byte(tx_byte), .cmd(cmd), .has_rx(has_rx),
    .wr_phase(wr_phase), .last(last)
  );

  vidseq_busport #(.ADR_W(ADR_W)) u_port (
    .clk(clk), .rst_n(rst_n), .go(go), .go_we(go_we), .go_adr(go_adr),
    .go_wdat(go_wdat), .done(port_done), .rdat(rdat), .bm_cyc(bm_cyc),
    .bm_stb(bm_stb), .bm_we(bm_we), .bm_adr(bm_adr), .bm_wdat(bm_wdat),
    .bm_rdat(bm_rdat), .bm_ack(bm_ack)
  );

  vidseq_gap #(.WAIT_TICKS(WAIT_TICKS)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(st == ST_REPORT), .tick(slow_tick),
    .clear(gap_clear)
  );

  assign req_ready = (st == ST_IDLE) && gap_clear;
  assign res_valid = (st == ST_REPORT);
  assign res_ok    = ok_q;
  assign res_chan  = chan_q;
  assign wp_o      = wp_q;

  // one bus access per visit of an access state
  always_comb begin
    go      = 1'b0;
    go_we   = 1'b0;
    go_adr  = ADR_SR;
    go_wdat = 8'h00;
    unique case (st)
      ST_MTX_REQ:  begin go = !inflight; go_we = 1'b1; go_adr = ADR_MTX; go_wdat = MTX_CLAIM; end
      ST_MTX_CHK:  begin go = !inflight; go_adr = ADR_MTX; end
      ST_BUSY,
      ST_POLL:     go = !inflight;
      ST_TX:       begin go = !inflight && has_tx; go_we = 1'b1; go_adr = ADR_TXDR; go_wdat = tx_byte; end
      ST_CMD:      begin go = !inflight; go_we = 1'b1; go_adr = ADR_CMD; go_wdat = cmd; end
      ST_RX:       begin go = !inflight; go_adr = ADR_RXDR; end
      ST_MTX_FREE: begin go = !inflight; go_we = 1'b1; go_adr = ADR_MTX; go_wdat = MTX_FREE; end
      default:     go = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      step     <= '0;
      inflight <= 1'b0;
      wp_q     <= 1'b1;
      mtx_held <= 1'b0;
      ok_q     <= 1'b0;
      chan_q   <= '0;
      slave_q  <= '0;
      reg_q    <= '0;
      data_q   <= '0;
      rx_lo    <= '0;
    end else begin
      if (go)             inflight <= 1'b1;
      else if (port_done) inflight <= 1'b0;

      unique case (st)
        ST_IDLE: if (req_valid && req_ready) begin
          chan_q  <= req_chan;
          slave_q <= req_slave;
          reg_q   <= req_reg;
          data_q  <= req_data;
          ok_q    <= 1'b0;
          st      <= MUTEX_EN ? ST_MTX_REQ : ST_BUSY;
        end
        ST_MTX_REQ: if (port_done) st <= ST_MTX_CHK;
        ST_MTX_CHK: if (port_done) begin
          if (rdat == MTX_CLAIM) begin
            mtx_held <= 1'b1;
            st       <= ST_BUSY;
          end else begin
            st <= ST_MTX_REQ;
          end
        end
        ST_BUSY: if (port_done && !rdat[SR_BUSY]) begin
          wp_q <= 1'b0;
          step <= '0;
          st   <= ST_TX;
        end
        ST_TX: begin
          if (!has_tx)        st <= ST_CMD;
          else if (port_done) st <= ST_CMD;
        end
        ST_CMD: if (port_done) st <= ST_POLL;
        ST_POLL: if (port_done) begin
          if (rdat[SR_ARBL]) begin
            if (wr_phase) begin
              wp_q <= 1'b1;
              st   <= ST_BUSY;
            end else begin
              ok_q <= 1'b0;
              st   <= ST_SETTLE;
            end
          end else if (rdat[SR_NACK]) begin
            ok_q <= 1'b0;
            st   <= ST_SETTLE;
          end else if (rdat[SR_DONE]) begin
            if (has_rx) begin
              st <= ST_RX;
            end else begin
              step <= step + 1'b1;
              st   <= ST_TX;
            end
          end
        end
        ST_RX: if (port_done) begin
          if (last) begin
            ok_q <= ({rdat, rx_lo} == {3'b000, data_q});
            st   <= ST_SETTLE;
          end else begin
            rx_lo <= rdat;
            step  <= step + 1'b1;
            st    <= ST_TX;
          end
        end
        ST_SETTLE: begin
          wp_q <= 1'b1;
          st   <= MUTEX_EN ? ST_MTX_FREE : ST_REPORT;
        end
        ST_MTX_FREE: if (port_done) begin
          mtx_held <= 1'b0;
          st       <= ST_REPORT;
        end
        ST_REPORT: st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  // R8: protected whenever no request is being worked on
  a_r8_wp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> wp_o);
  // R2: controller registers only touched while the mutex is owned
  a_r2_mutex_first: assert property (@(posedge clk) disable iff (!rst_n)
    (go && go_adr != ADR_MTX) |-> (mtx_held || !MUTEX_EN));
  // R5: arbitration loss in the write phase raises write-protect
  a_r5_arbl_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_POLL && port_done && rdat[SR_ARBL] && wr_phase) |=> wp_o);
  // R8: single-cycle result pulse
  a_r8_res_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R11: one handshake, then back-pressure
  a_r11_one_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R8: mutex freed and target protected at the result
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (wp_o && !mtx_held));
endmodule

// File: tb/vidseq_master_tb.sv
`timescale 1ns/1ps
module vidseq_master_tb;
  localparam int         CH_W  = 4;
  localparam int         WAIT  = 3;
  localparam logic [6:0] OWNER = 7'h05;
  localparam logic [6:0] OTHER = 7'h22;
  localparam logic [7:0] A_CMD = 8'h01, A_SR = 8'h02, A_TX = 8'h03, A_RX = 8'h04, A_MTX = 8'h10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, slow_tick = 1'b0, req_valid = 1'b0;
  logic req_ready, res_valid, res_ok, wp_o;
  logic [CH_W-1:0] req_chan = '0, res_chan;
  logic [6:0] req_slave = '0;
  logic [7:0] req_reg = '0;
  logic [12:0] req_data = '0;
  logic bm_cyc, bm_stb, bm_we, bm_ack = 1'b0;
  logic [7:0] bm_adr, bm_wdat, bm_rdat = '0;

  vidseq_master #(.CH_W(CH_W), .MUTEX_EN(1'b1), .OWNER_ID(OWNER), .WAIT_TICKS(WAIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .req_valid(req_valid),
    .req_ready(req_ready), .req_chan(req_chan), .req_slave(req_slave),
    .req_reg(req_reg), .req_data(req_data), .res_valid(res_valid),
    .res_ok(res_ok), .res_chan(res_chan), .bm_cyc(bm_cyc), .bm_stb(bm_stb),
    .bm_we(bm_we), .bm_adr(bm_adr), .bm_wdat(bm_wdat), .bm_rdat(bm_rdat),
    .bm_ack(bm_ack), .wp_o(wp_o)
  );

  int checks = 0, errors = 0;
  bit finished = 0, mon_on = 0, in_flight = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // behavioural model of mutex, controller and target
  logic [7:0] mem [0:255];
  logic [7:0] mtx_val = '0, txdr = '0, rxdr = '0, t_ptr = '0;
  logic [6:0] tgt_addr = 7'h21;
  bit owned = 0, have_res = 0, r_arbl = 0, r_nack = 0, r_done = 0;
  bit t_sel = 0, t_rd = 0, t_first = 0, arb_wait = 0, seen_wp_hi = 0, nacked = 0, corrupt = 0;
  int other_hold = 0, busy_left = 0, pend = 0, cmd_cnt = 0, arb_at = 0;
  int start_cnt = 0, rx_reads = 0, mtx_claims = 0, div = 0;

  task automatic do_cmd(input logic [7:0] c);
    cmd_cnt++;
    pend = 1; have_res = 1; r_arbl = 0; r_nack = 0; r_done = 1;
    if (c[7]) begin
      start_cnt++;
      chk(busy_left == 0, "R3", "START while bus busy", busy_left, 0);
      if (arb_wait) begin
        chk(seen_wp_hi, "R5", "wp raised before retransmit", seen_wp_hi, 1);
        arb_wait = 0;
      end
    end
    if (cmd_cnt == arb_at) begin
      r_arbl = 1; r_done = 0; t_sel = 0;
    end else if (c[7]) begin
      if (txdr[7:1] == tgt_addr) begin
        t_sel = 1; t_rd = txdr[0]; t_first = !txdr[0];
      end else begin
        t_sel = 0; r_nack = 1; r_done = 0; nacked = 1;
      end
    end else if (c[4]) begin
      chk(!nacked, "R9", "byte sent after NACK", 1, 0);
      if (t_sel && !t_rd) begin
        if (t_first) begin
          t_ptr = txdr; t_first = 0;
        end else begin
          chk(!wp_o, "R3", "wp low on data byte", wp_o, 0);
          if (!wp_o) mem[t_ptr] = txdr;
          t_ptr = t_ptr + 1;
        end
      end
    end else if (c[5]) begin
      if (t_sel && t_rd) begin
        rxdr = mem[t_ptr] ^ {7'b0, corrupt};
        t_ptr = t_ptr + 1;
      end
    end
    if (c[6]) t_sel = 0;
  endtask

  task automatic do_access();
    logic [7:0] v;
    v = '0;
    if (bm_adr == A_MTX) begin
      if (bm_we) begin
        if (bm_wdat == {1'b1, OWNER}) begin
          mtx_claims++;
          if (other_hold > 0) begin other_hold--; mtx_val = {1'b1, OTHER}; end
          else begin mtx_val = bm_wdat; owned = 1; end
        end else if (bm_wdat == {1'b0, OWNER}) begin
          owned = 0; mtx_val = '0;
        end
      end
      v = mtx_val;
    end else begin
      chk(owned, "R2", "controller access without mutex", owned, 1);
      if (bm_adr == A_SR && !bm_we) begin
        if (busy_left > 0) begin v[7] = 1; busy_left--; end
        else if (pend > 0) pend--;
        else if (have_res) begin
          v[3] = r_arbl; v[2] = r_nack; v[0] = r_done; have_res = 0;
          if (r_arbl) begin busy_left = 2; arb_wait = 1; seen_wp_hi = 0; end
        end
      end else if (bm_adr == A_TX && bm_we) txdr = bm_wdat;
      else if (bm_adr == A_RX && !bm_we) begin
        v = rxdr; rx_reads++;
        chk(!nacked, "R9", "read-back after NACK", 1, 0);
      end else if (bm_adr == A_CMD && bm_we) do_cmd(bm_wdat);
    end
    bm_rdat = v;
  endtask

  // responder and slow clock, driven at the falling edge
  initial forever begin
    @(negedge clk);
    div = (div + 1) % 5;
    slow_tick = (div == 0);
    if (arb_wait && wp_o) seen_wp_hi = 1;
    if (bm_ack) bm_ack = 1'b0;
    else if (bm_cyc && bm_stb) begin do_access(); bm_ack = 1'b1; end
  end

  // per-clock comparison with the model
  int res_cnt = 0, ticks = 0;
  bit last_ok = 0, armed = 0, skip = 0;
  logic [CH_W-1:0] last_chan = '0;
  initial forever begin
    @(posedge clk); #1;
    if (mon_on) begin
      chk(!bm_cyc || in_flight, "R1", "bus access without request", bm_cyc, 0);
      chk(owned || wp_o, "R8", "wp low without mutex", wp_o, 1);
      chk(!in_flight || !req_ready, "R11", "ready while busy", req_ready, 0);
      if (res_valid) begin
        res_cnt++; last_ok = res_ok; last_chan = res_chan; in_flight = 0;
        chk(!owned, "R8", "mutex released at result", owned, 0);
        chk(wp_o, "R8", "wp high at result", wp_o, 1);
        armed = 1; skip = 1; ticks = 0;
      end else if (armed) begin
        if (skip) skip = 0;
        else begin
          if (slow_tick) ticks++;
          if (req_ready) begin
            chk(ticks == WAIT, "R10", "slow ticks in gap", ticks, WAIT);
            armed = 0;
          end
        end
      end
    end
  end

  task automatic run(input logic [3:0] ch, input logic [6:0] sa, input logic [7:0] rg,
                     input logic [12:0] d, input bit exp_ok, input string req);
    int n0;
    cmd_cnt = 0; start_cnt = 0; rx_reads = 0; mtx_claims = 0; nacked = 0;
    @(negedge clk);
    req_chan = ch; req_slave = sa; req_reg = rg; req_data = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    n0 = res_cnt;
    @(negedge clk);
    req_valid = 1'b0; in_flight = 1;
    wait (res_cnt != n0);
    chk(last_ok == exp_ok, req, "result ok flag", last_ok, exp_ok);
    chk(last_chan == ch, "R8", "result channel", last_chan, ch);
    corrupt = 0; arb_at = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk(wp_o, "R8", "wp after reset", wp_o, 1);
    chk(!bm_cyc, "R1", "no access in reset", bm_cyc, 0);
    chk(!res_valid, "R8", "no result in reset", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;
    chk(req_ready, "R10", "ready after reset", req_ready, 1);
    repeat (6) @(negedge clk);
    chk(!bm_cyc, "R1", "idle without request", bm_cyc, 0);

    // plain request
    run(4'd3, 7'h21, 8'h10, 13'h1ABC, 1, "R6");
    chk(mem[8'h10] == 8'hBC, "R4", "low byte stored", mem[8'h10], 8'hBC);
    chk(mem[8'h11] == 8'h1A, "R4", "high byte stored", mem[8'h11], 8'h1A);
    chk(rx_reads == 2, "R6", "read-back bytes", rx_reads, 2);
    chk(start_cnt == 3, "R12", "START count", start_cnt, 3);

    // mutex held elsewhere for two tries
    other_hold = 2;
    run(4'd1, 7'h21, 8'h20, 13'h0555, 1, "R2");
    chk(mtx_claims == 3, "R2", "mutex claim attempts", mtx_claims, 3);

    // bus busy before start
    busy_left = 3;
    run(4'd2, 7'h21, 8'h30, 13'h1234, 1, "R3");
    chk(mem[8'h30] == 8'h34 && mem[8'h31] == 8'h12, "R3", "data after busy wait", {mem[8'h31], mem[8'h30]}, 16'h1234);

    // arbitration loss on the low data byte
    arb_at = 3;
    run(4'd5, 7'h21, 8'h40, 13'h0F0F, 1, "R5");
    chk(start_cnt == 4, "R5", "START count with retransmit", start_cnt, 4);
    chk(mem[8'h40] == 8'h0F && mem[8'h41] == 8'h0F, "R5", "data after retransmit", {mem[8'h41], mem[8'h40]}, 16'h0F0F);

    // corrupted read-back
    corrupt = 1;
    run(4'd6, 7'h21, 8'h50, 13'h0AAA, 0, "R7");
    chk(rx_reads == 2, "R7", "read-back done", rx_reads, 2);

    // absent target address
    run(4'd7, 7'h33, 8'h60, 13'h0001, 0, "R9");
    chk(rx_reads == 0, "R9", "no read-back after NACK", rx_reads, 0);
    chk(cmd_cnt == 1, "R9", "commands after NACK", cmd_cnt, 1);

    // extreme values and last register pair
    run(4'd15, 7'h21, 8'hFE, 13'h1FFF, 1, "R4");
    chk(mem[8'hFE] == 8'hFF && mem[8'hFF] == 8'h1F, "R4", "max value packing", {mem[8'hFF], mem[8'hFE]}, 16'h1FFF);
    run(4'd0, 7'h21, 8'hFE, 13'h0000, 1, "R12");
    chk(mem[8'hFE] == 8'h00 && mem[8'hFF] == 8'h00, "R4", "zero value packing", {mem[8'hFF], mem[8'hFE]}, 0);

    chk(res_cnt == 8, "R11", "results per handshake", res_cnt, 8);
    repeat (40) @(negedge clk);
    finish_run();
  end
endmodule